// File: doc/BRIEF.md
# Differential Sparse Bitvector Compressor

This block decides whether an older intermediate bitvector of a depth-first itemset search can be kept on chip. The older vector A is presented together with the newest, uncompressed vector B, one word pair per valid cycle. Each pair is XORed. Words of the difference that are entirely zero are dropped, and each surviving word is tagged with its word position. The packed difference waits in a staging area until the whole vector has been seen. Once the final size is known, the block admits it to a scratchpad only if it passes a compression-ratio test and also fits in the space left. Otherwise A is streamed out word by word on an uncompressed writeback port for off-chip storage.

Each compression targets one slot of an address table. The slot records the scratchpad start, the number of kept words and whether the data stayed on chip. A reconstruction request names a slot and replays the same B vector. The block returns A by XORing each B word with the stored difference word carrying that position, or with zero where no word was stored.

Top module: `diffsparse_compressor`

## Requirements
- R1: After reset the block is idle: `busy`, `offValid`, `done` and `decValid` are low. While idle, neither `offValid` nor `done` is asserted.
- R2: `doneCount` equals the number of word positions where `aWord ^ bWord` is non-zero over the NUM_WORDS accepted word pairs.
- R3: A result is kept on chip only if doneCount × (WORD_W + log2(NUM_WORDS)) × 100 ≤ THRESH_PCT × NUM_WORDS × WORD_W. With the defaults (32-bit words, 16 words, 50 %) this means at most 7 kept words.
- R4: A result that passes R3 is still sent off chip if the occupied scratchpad entries plus doneCount would exceed SP_DEPTH. Filling the scratchpad exactly to SP_DEPTH is allowed. Occupancy grows only by doneCount, and only on an on-chip verdict.
- R5: On an off-chip verdict, `offValid` is high for NUM_WORDS consecutive cycles, starting two cycles after the cycle that accepted the last word. `offIdx` runs 0 to NUM_WORDS-1 and `offWord` carries the matching word of A.
- R6: `done` is a one-cycle pulse carrying `doneOnChip` and `doneCount`. On an off-chip verdict it comes in the cycle after the last `offValid`. On an on-chip verdict it comes doneCount+2 cycles after the last word.
- R7: Reconstructing an on-chip slot while replaying that slot's B vector returns the original A words. Each `decWord` is valid, with `decValid` high, in the cycle after its B word is accepted.
- R8: Reconstructing a slot recorded off chip gives `decOnChip` low and `decWord` equal to the B word presented.
- R9: When A equals B, no words are kept, the verdict is on chip, no scratchpad space is used, and reconstruction returns B.
- R10: On-chip results are appended one after another in the scratchpad. An earlier slot still reconstructs correctly after later slots have been stored.
- R11: During a load, a cycle with `inValid` low accepts no word and does not affect the count, the verdict or the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpStart | input | 1 | Begin a compression into slot `entrySel` (idle only; wins over `decStart`) |
| decStart | input | 1 | Begin a reconstruction of slot `entrySel` (idle only) |
| entrySel | input | ENT_W | Address-table slot |
| inValid | input | 1 | Word pair on `aWord`/`bWord` is valid |
| aWord | input | WORD_W | Word of the older vector A |
| bWord | input | WORD_W | Word of the newest vector B |
| busy | output | 1 | An operation is in progress |
| offValid | output | 1 | Uncompressed writeback word valid |
| offIdx | output | IDX_W | Word position of `offWord` |
| offWord | output | WORD_W | Word of A for off-chip storage |
| done | output | 1 | Compression verdict pulse |
| doneOnChip | output | 1 | Verdict: 1 = kept in scratchpad |
| doneCount | output | CNT_W | Number of non-zero difference words |
| decValid | output | 1 | Reconstructed word valid |
| decWord | output | WORD_W | Reconstructed word of A |
| decOnChip | output | 1 | Slot being reconstructed is on chip |

## Verification
The verdict cycle carries no output. Writeback words start two cycles after the last accepted word. `done` follows either NUM_WORDS writeback cycles or doneCount silent store cycles. Reconstructed words appear one cycle after each B word. The bench drives inputs on the falling edge and checks every output on each falling edge against a behavioural model that walks this schedule. A stray or missing pulse in any cycle is therefore reported.

// File: rtl/fim_cmp_pkg.sv
package fim_cmp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_DECIDE,
    S_STORE,
    S_SPILL,
    S_FINISH,
    S_DLOAD
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrLoad;
    logic takeWord;
    logic decide;
    logic storeWord;
    logic spillWord;
    logic finish;
    logic decLoad;
    logic decStep;
  } strobe_t;

endpackage

// File: rtl/dsc_ctrl.sv
module dsc_ctrl
  import fim_cmp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpStart,
  input  logic             decStart,
  input  logic             inValid,
  input  logic [CNT_W-1:0] keptCnt,
  input  logic             admit,
  output strobe_t          st,
  output logic [IDX_W-1:0] wordIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             busy
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  ctlState_t state, nxt;

  logic lastWord;
  logic lastStore;

  assign lastWord  = (wordIdx == LAST_IDX);
  assign lastStore = ((CNT_W'(rdIdx) + CNT_W'(1)) == keptCnt);
  assign busy      = (state != S_IDLE);

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (cmpStart) begin
          st.clrLoad = 1'b1;
          nxt        = S_LOAD;
        end else if (decStart) begin
          st.decLoad = 1'b1;
          nxt        = S_DLOAD;
        end
      end
      S_LOAD: begin
        st.takeWord = inValid;
        if (inValid && lastWord) nxt = S_DECIDE;
      end
      S_DECIDE: begin
        st.decide = 1'b1;
        if (!admit)              nxt = S_SPILL;
        else if (keptCnt == '0)  nxt = S_FINISH;
        else                     nxt = S_STORE;
      end
      S_STORE: begin
        st.storeWord = 1'b1;
        if (lastStore) nxt = S_FINISH;
      end
      S_SPILL: begin
        st.spillWord = 1'b1;
        if (rdIdx == LAST_IDX) nxt = S_FINISH;
      end
      S_FINISH: begin
        st.finish = 1'b1;
        nxt       = S_IDLE;
      end
      S_DLOAD: begin
        st.decStep = inValid;
        if (inValid && lastWord) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordIdx <= '0;
      rdIdx   <= '0;
    end else begin
      state <= nxt;
      unique case (state)
        S_IDLE:           begin wordIdx <= '0; rdIdx <= '0; end
        S_LOAD, S_DLOAD:  if (inValid) wordIdx <= wordIdx + 1'b1;
        S_DECIDE:         rdIdx <= '0;
        S_STORE, S_SPILL: rdIdx <= rdIdx + 1'b1;
        default:          ;
      endcase
    end
  end

endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import fim_cmp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 16,
  parameter int SP_DEPTH    = 32,
  parameter int NUM_ENTRIES = 8,
  parameter int THRESH_PCT  = 50,
  parameter int IDX_W       = 4,
  parameter int CNT_W       = 5,
  parameter int SP_AW       = 5,
  parameter int OCC_W       = 6,
  parameter int ENT_W       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ENT_W-1:0]  entrySel,
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  keptCnt,
  output logic              admit,
  output logic [WORD_W-1:0] offWord,
  output logic              verdict,
  output logic [OCC_W-1:0]  spUsed,
  output logic              decValid,
  output logic [WORD_W-1:0] decWord,
  output logic              decOnChip
);

  localparam int ENT_BITS = WORD_W + IDX_W;
  localparam int MAX_KEEP = (THRESH_PCT * NUM_WORDS * WORD_W) / (100 * ENT_BITS);

  // staging area for one vector
  logic [WORD_W-1:0] stageA   [NUM_WORDS];
  logic [WORD_W-1:0] listData [NUM_WORDS];
  logic [IDX_W-1:0]  listIdx  [NUM_WORDS];

  // scratchpad of tagged difference words
  logic [WORD_W-1:0] spData [SP_DEPTH];
  logic [IDX_W-1:0]  spIdx  [SP_DEPTH];

  // address table
  logic [SP_AW-1:0]  tStart [NUM_ENTRIES];
  logic [CNT_W-1:0]  tCount [NUM_ENTRIES];
  logic              tOn    [NUM_ENTRIES];

  logic [ENT_W-1:0]  entryReg;
  logic [OCC_W-1:0]  occ;
  logic [SP_AW-1:0]  dPtr;
  logic [CNT_W-1:0]  dLeft;
  logic              dOn;

  logic [WORD_W-1:0] diffWord;
  logic              diffLive;
  logic [SP_AW-1:0]  spWrAddr;
  logic              ratioOk;
  logic              fitOk;
  logic              decHit;

  assign diffWord = aWord ^ bWord;
  assign diffLive = (diffWord != '0);
  assign spWrAddr = SP_AW'(occ) + SP_AW'(rdIdx);
  assign ratioOk  = (int'(keptCnt) <= MAX_KEEP);
  assign fitOk    = ((int'(occ) + int'(keptCnt)) <= SP_DEPTH);
  assign admit    = ratioOk && fitOk;
  assign offWord  = stageA[rdIdx];
  assign spUsed   = occ;
  assign decHit   = dOn && (dLeft != '0) && (spIdx[dPtr] == wordIdx);

  // storage arrays without reset
  always_ff @(posedge clk) begin
    if (st.takeWord) begin
      stageA[wordIdx] <= aWord;
      if (diffLive) begin
        listData[keptCnt[IDX_W-1:0]] <= diffWord;
        listIdx[keptCnt[IDX_W-1:0]]  <= wordIdx;
      end
    end
    if (st.storeWord) begin
      spData[spWrAddr] <= listData[rdIdx];
      spIdx[spWrAddr]  <= listIdx[rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keptCnt   <= '0;
      verdict   <= 1'b0;
      entryReg  <= '0;
      occ       <= '0;
      dPtr      <= '0;
      dLeft     <= '0;
      dOn       <= 1'b0;
      decValid  <= 1'b0;
      decWord   <= '0;
      decOnChip <= 1'b0;
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        tStart[e] <= '0;
        tCount[e] <= '0;
        tOn[e]    <= 1'b0;
      end
    end else begin
      decValid <= st.decStep;
      if (st.clrLoad) begin
        keptCnt  <= '0;
        entryReg <= entrySel;
      end
      if (st.takeWord && diffLive) keptCnt <= keptCnt + 1'b1;
      if (st.decide) verdict <= admit;
      if (st.finish) begin
        tOn[entryReg]    <= verdict;
        tStart[entryReg] <= verdict ? SP_AW'(occ) : '0;
        tCount[entryReg] <= verdict ? keptCnt : '0;
        if (verdict) occ <= occ + OCC_W'(keptCnt);
      end
      if (st.decLoad) begin
        dPtr  <= tStart[entrySel];
        dLeft <= tCount[entrySel];
        dOn   <= tOn[entrySel];
      end
      if (st.decStep) begin
        decWord   <= (decHit ? spData[dPtr] : '0) ^ bWord;
        decOnChip <= dOn;
        if (decHit) begin
          dPtr  <= dPtr + 1'b1;
          dLeft <= dLeft - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/diffsparse_compressor.sv
module diffsparse_compressor
  import fim_cmp_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 16,
  parameter int SP_DEPTH    = 32,
  parameter int NUM_ENTRIES = 8,
  parameter int THRESH_PCT  = 50,
  localparam int IDX_W      = $clog2(NUM_WORDS),
  localparam int CNT_W      = $clog2(NUM_WORDS + 1),
  localparam int SP_AW      = $clog2(SP_DEPTH),
  localparam int OCC_W      = $clog2(SP_DEPTH + 1),
  localparam int ENT_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpStart,
  input  logic              decStart,
  input  logic [ENT_W-1:0]  entrySel,
  input  logic              inValid,
  input  logic [WORD_W-1:0] aWord,
  input  logic [WORD_W-1:0] bWord,
  output logic              busy,
  output logic              offValid,
  output logic [IDX_W-1:0]  offIdx,
  output logic [WORD_W-1:0] offWord,
  output logic              done,
  output logic              doneOnChip,
  output logic [CNT_W-1:0]  doneCount,
  output logic              decValid,
  output logic [WORD_W-1:0] decWord,
  output logic              decOnChip
);

  strobe_t          st;
  logic [IDX_W-1:0] wordIdx;
  logic [IDX_W-1:0] rdIdx;
  logic [CNT_W-1:0] keptCnt;
  logic             admit;
  logic             verdict;
  logic [OCC_W-1:0] spUsed;

  dsc_ctrl #(
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmpStart(cmpStart), .decStart(decStart),
    .inValid(inValid), .keptCnt(keptCnt), .admit(admit), .st(st),
    .wordIdx(wordIdx), .rdIdx(rdIdx), .busy(busy)
  );

  dsc_datapath #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SP_DEPTH(SP_DEPTH),
    .NUM_ENTRIES(NUM_ENTRIES), .THRESH_PCT(THRESH_PCT), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .SP_AW(SP_AW), .OCC_W(OCC_W), .ENT_W(ENT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .entrySel(entrySel), .aWord(aWord),
    .bWord(bWord), .wordIdx(wordIdx), .rdIdx(rdIdx), .keptCnt(keptCnt),
    .admit(admit), .offWord(offWord), .verdict(verdict), .spUsed(spUsed),
    .decValid(decValid), .decWord(decWord), .decOnChip(decOnChip)
  );

  assign offValid   = st.spillWord;
  assign offIdx     = rdIdx;
  assign done       = st.finish;
  assign doneOnChip = verdict;
  assign doneCount  = keptCnt;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 16,
  parameter int SP_DEPTH   = 32,
  parameter int THRESH_PCT = 50,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 5,
  parameter int OCC_W      = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              inValid,
  input logic [WORD_W-1:0] bWord,
  input logic              offValid,
  input logic [IDX_W-1:0]  offIdx,
  input logic              done,
  input logic              doneOnChip,
  input logic [CNT_W-1:0]  doneCount,
  input logic              decValid,
  input logic [WORD_W-1:0] decWord,
  input logic              decOnChip,
  input logic [OCC_W-1:0]  spUsed
);

  localparam int MAX_KEEP = (THRESH_PCT * NUM_WORDS * WORD_W) / (100 * (WORD_W + IDX_W));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!offValid && !done));

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (int'(doneCount) <= NUM_WORDS));

  a_r3_ratio_bound: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneOnChip) |-> (int'(doneCount) <= MAX_KEEP));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    int'(spUsed) <= SP_DEPTH);

  a_r4_growth_on_verdict: assert property (@(posedge clk) disable iff (!rstN)
    (spUsed != $past(spUsed)) |->
      ($past(done && doneOnChip) && (spUsed == $past(spUsed) + OCC_W'($past(doneCount)))));

  a_r5_spill_starts_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(offValid) |-> (offIdx == '0));

  a_r5_spill_steps: assert property (@(posedge clk) disable iff (!rstN)
    (offValid && $past(offValid)) |-> (offIdx == $past(offIdx) + 1'b1));

  a_r6_done_after_spill: assert property (@(posedge clk) disable iff (!rstN)
    $fell(offValid) |-> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_dec_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(inValid));

  a_r8_offchip_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !decOnChip) |-> (decWord == $past(bWord)));

endmodule

bind diffsparse_compressor dsc_checker #(
  .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SP_DEPTH(SP_DEPTH),
  .THRESH_PCT(THRESH_PCT), .IDX_W(IDX_W), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .inValid(inValid), .bWord(bWord),
  .offValid(offValid), .offIdx(offIdx), .done(done), .doneOnChip(doneOnChip),
  .doneCount(doneCount), .decValid(decValid), .decWord(decWord),
  .decOnChip(decOnChip), .spUsed(spUsed)
);

// File: tb/diffsparse_compressor_test.sv
`timescale 1ns/1ps
module diffsparse_compressor_test;

  localparam int NW   = 16;
  localparam int CAP  = 32;
  localparam int MAXK = 7;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpStart = 1'b0;
  logic        decStart = 1'b0;
  logic [2:0]  entrySel = '0;
  logic        inValid = 1'b0;
  logic [31:0] aWord = '0;
  logic [31:0] bWord = '0;
  logic        busy, offValid, done, doneOnChip, decValid, decOnChip;
  logic [3:0]  offIdx;
  logic [31:0] offWord, decWord;
  logic [4:0]  doneCount;

  int tests = 0;
  int fails = 0;
  int occ = 0;

  logic [31:0] mA [8][NW];
  logic [31:0] mB [8][NW];
  bit          mOn [8];

  always #(HALF) clk = ~clk;

  diffsparse_compressor uut (
    .clk(clk), .rstN(rstN), .cmpStart(cmpStart), .decStart(decStart),
    .entrySel(entrySel), .inValid(inValid), .aWord(aWord), .bWord(bWord),
    .busy(busy), .offValid(offValid), .offIdx(offIdx), .offWord(offWord),
    .done(done), .doneOnChip(doneOnChip), .doneCount(doneCount),
    .decValid(decValid), .decWord(decWord), .decOnChip(decOnChip)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mix(input int seed, input int i);
    return 32'h9E3779B9 * 32'(seed * 37 + i + 1) ^ 32'h5A5A0F0F;
  endfunction

  // compress vectors built from seed; K positions differ (spread by i*5 mod 16)
  task automatic doCompress(input int ent, input int seed, input int K, input int gapAt, input string tag);
    logic [31:0] a [NW];
    logic [31:0] b [NW];
    bit expOn;
    for (int i = 0; i < NW; i++) begin
      a[i] = mix(seed, i);
      b[i] = (((i * 5) % NW) < K) ? (a[i] ^ (32'h8000_0000 | (32'h1 << i))) : a[i];
    end
    expOn = (K <= MAXK) && (occ + K <= CAP);
    @(negedge clk);
    cmpStart = 1'b1; entrySel = 3'(ent);
    @(negedge clk);
    cmpStart = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'd1);
    for (int i = 0; i < NW; i++) begin
      if (i == gapAt) begin
        inValid = 1'b0; aWord = 32'hFFFF_FFFF; bWord = 32'h0;
        @(negedge clk);
      end
      inValid = 1'b1; aWord = a[i]; bWord = b[i];
      @(negedge clk);
      chk(!done && !offValid, "R11 quiet during load", {62'd0, done, offValid}, 64'd0);
    end
    inValid = 1'b0;
    chk(!done && !offValid, "R5 decide cycle silent", {62'd0, done, offValid}, 64'd0);
    if (!expOn) begin
      for (int i = 0; i < NW; i++) begin
        @(negedge clk);
        chk(offValid == 1'b1, "R5 writeback valid", 64'(offValid), 64'd1);
        chk(offIdx == 4'(i), "R5 writeback index", 64'(offIdx), 64'(i));
        chk(offWord == a[i], "R5 writeback word", 64'(offWord), 64'(a[i]));
        chk(!done, "R6 no early done", 64'(done), 64'd0);
      end
    end else begin
      for (int i = 0; i < K; i++) begin
        @(negedge clk);
        chk(!offValid && !done, "R6 store cycles silent", {62'd0, done, offValid}, 64'd0);
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 done pulse", 64'(done), 64'd1);
    chk(offValid == 1'b0, "R5 writeback ended", 64'(offValid), 64'd0);
    chk(doneCount == 5'(K), "R2 kept count", 64'(doneCount), 64'(K));
    chk(doneOnChip == expOn, tag, 64'(doneOnChip), 64'(expOn));
    @(negedge clk);
    chk(!done && !busy, "R6 back to idle", {62'd0, done, busy}, 64'd0);
    mOn[ent] = expOn;
    for (int i = 0; i < NW; i++) begin mA[ent][i] = a[i]; mB[ent][i] = b[i]; end
    if (expOn) occ += K;
  endtask

  task automatic doDecompress(input int ent, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    decStart = 1'b1; entrySel = 3'(ent);
    @(negedge clk);
    decStart = 1'b0;
    for (int i = 0; i < NW; i++) begin
      inValid = 1'b1; bWord = mB[ent][i]; aWord = 32'hDEAD_BEEF;
      @(negedge clk);
      exp = mOn[ent] ? mA[ent][i] : mB[ent][i];
      chk(decValid == 1'b1, {tag, " valid"}, 64'(decValid), 64'd1);
      chk(decWord == exp, {tag, " word"}, 64'(decWord), 64'(exp));
      chk(decOnChip == mOn[ent], {tag, " flag"}, 64'(decOnChip), 64'(mOn[ent]));
    end
    inValid = 1'b0;
    @(negedge clk);
    chk(!decValid && !busy, {tag, " ends"}, {62'd0, decValid, busy}, 64'd0);
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !offValid && !done && !decValid, "R1 reset outputs",
        {60'd0, busy, offValid, done, decValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !offValid && !done, "R1 idle after reset", {61'd0, busy, offValid, done}, 64'd0);

    doCompress(0, 1, 3, -1, "R3 small diff on chip");
    doDecompress(0, "R7 rebuild slot 0");
    doCompress(1, 2, 7, 5, "R3 threshold edge on chip, R11 gap");
    doCompress(2, 3, 8, -1, "R3 one over threshold off chip");
    doDecompress(2, "R8 off-chip passthrough");
    doCompress(3, 4, 0, -1, "R9 equal vectors on chip");
    doDecompress(3, "R9 rebuild equal");
    doCompress(4, 5, 7, -1, "R4 fill step");
    doCompress(5, 6, 7, -1, "R4 fill step");
    doCompress(6, 7, 7, -1, "R4 fill step");
    doCompress(7, 8, 2, -1, "R4 capacity exceeded off chip");
    doCompress(7, 9, 1, -1, "R4 exact fill on chip");
    doDecompress(7, "R4 rebuild last slot");
    doDecompress(6, "R10 rebuild slot 6");
    doDecompress(1, "R10 rebuild earlier slot");
    doDecompress(0, "R10 rebuild first slot");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule